// File: doc/BRIEF.md
# Critical Exception Entry and Return Sequencer

This block is the control unit that moves a 32-bit processor core into and out of its critical-class exception handlers. It watches three sources: an external critical request line, bus errors reported on instruction fetches, and bus errors reported on data accesses. When an event is accepted it stores a return address and the current status word into a dedicated critical save pair. This pair is separate from the save pair used by ordinary exceptions. The block then clears the status word's enable and mode bits and steers the core to a vector built from a 16-bit prefix and a fixed 16-bit offset.

A fetch bus error does not trap at once. The block only records it together with its fetch address. The machine check is raised later, when the core signals that it is executing the instruction at that address. If the core is redirected first, the record is dropped. A data bus error raises a machine check with the next sequential address as the return point. A return-from-critical command reloads the program counter and the status word from the save pair.

The status register itself lives outside the block. The block reads it on `status_i` and writes it back through `status_we_o` and `status_o`. Each entry and each return gives a one-cycle redirect pulse with the new program counter.

Top module: `crit_exc_sequencer`

## Requirements
- R1: When a critical input is accepted, `csave_pc_o` takes the `next_pc_i` value of the accepting cycle and `csave_st_o` takes `status_i` of that cycle. Both are visible in the following cycle.
- R2: Status bit layout: bit 0 external enable, bit 1 critical enable, bit 2 machine-check enable, bit 3 user mode, bit 4 wait enable, bit 5 debug enable, bits 6 and 7 instruction and data translation, bits 8 to 13 coprocessor and watchdog-debug enables. Critical-input entry writes bits 0, 1 and 3 to 13 as 0. Bit 2 and bits 31:14 keep their values.
- R3: On critical-input entry, `target_pc_o` is `{vec_prefix_i, 16'h0100}`.
- R4: On machine-check entry, `target_pc_o` is `{vec_prefix_i, 16'h0200}`. The written status has bits 0 to 13 cleared, including bit 2, and bits 31:14 kept.
- R5: A data bus error records the `next_pc_i` of its own cycle. The data machine check is taken at the earliest one cycle later, and it saves that recorded address.
- R6: A fetch bus error only records `ifetch_addr_i`. An instruction machine check is raised once `exec_valid_i` is high with `exec_pc_i` equal to the recorded address. The check saves that address and is taken at the earliest one cycle after the execute strobe.
- R7: A critical input is accepted only while status bit 1 is 1. A machine check is taken only while status bit 2 is 1. A blocked request stays pending and is served once it is enabled.
- R8: Acceptance order is instruction machine check, then data machine check, then critical input, then return. A return that loses to an entry has no effect. No event is accepted in a cycle in which `redirect_o` is high.
- R9: A return-from-critical drives `target_pc_o` from `csave_pc_o` and `status_o` from `csave_st_o`. The save pair is left unchanged.
- R10: Any accepted entry or return discards a recorded fetch bus error that has not yet reached execution.
- R11: Every entry and every return gives `redirect_o` and `status_we_o` high for exactly one cycle.
- R12: During and after reset, before any event, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| crit_req_i | input | 1 | External critical request, held high until served |
| ifetch_err_i | input | 1 | Bus error on an instruction fetch |
| ifetch_addr_i | input | AW | Address of the failing fetch |
| exec_valid_i | input | 1 | An instruction is starting execution |
| exec_pc_i | input | AW | Address of the executing instruction |
| dbus_err_i | input | 1 | Bus error on a data access |
| next_pc_i | input | AW | Address of the next sequential instruction |
| rfc_cmd_i | input | 1 | Return-from-critical command |
| status_i | input | 32 | Current status word |
| vec_prefix_i | input | PFX_W | Upper bits of every vector |
| redirect_o | output | 1 | One-cycle redirect pulse |
| target_pc_o | output | AW | New program counter, valid with the pulse |
| status_we_o | output | 1 | Status write enable |
| status_o | output | 32 | Status word to write |
| csave_pc_o | output | AW | Critical save-PC register |
| csave_st_o | output | 32 | Critical save-status register |

## Verification
A critical input or a return is accepted at the first clock edge that sees it. The result is on the outputs one cycle later. A data or instruction machine check needs one more edge to become pending, so its redirect appears two edges after the error or the execute strobe. The bench drives stimulus 2 ns after a rising edge and samples at the same point after each following edge. It counts those edges before each comparison, and it confirms the absence of a redirect on every cycle in which a blocked or discarded event must not act. The bench also keeps its own copy of the status register, updated from the write port, so that the enable gating sees the rewritten bits exactly as a core would.

// File: rtl/crit_seq_pkg.sv
// Package: shared status bit positions, action encoding and clear masks
// for the critical exception sequencer. Assumes a 32-bit status word.
package crit_seq_pkg;

    localparam int ST_W = 32;

    // status bit positions
    localparam int SB_EXT_EN  = 0;
    localparam int SB_CRIT_EN = 1;
    localparam int SB_MCHK_EN = 2;
    localparam int SB_USER    = 3;
    localparam int SB_WAIT_EN = 4;
    localparam int SB_DBG_EN  = 5;
    localparam int SB_ITRANS  = 6;
    localparam int SB_DTRANS  = 7;
    localparam int SB_LAST    = 13;   // bits 8..13: coprocessor / watchdog-debug enables

    typedef enum logic [2:0] {
        ACT_NONE = 3'd0,
        ACT_IMC  = 3'd1,
        ACT_DMC  = 3'd2,
        ACT_CRIT = 3'd3,
        ACT_RET  = 3'd4
    } act_e;

    // Bits forced to 0 on entry; machine-check enable only for machine checks.
    function automatic logic [ST_W-1:0] entry_clear_mask(input logic is_mchk);
        logic [ST_W-1:0] m;
        m = '0;
        for (int b = 0; b <= SB_LAST; b++) begin
            m[b] = 1'b1;
        end
        m[SB_MCHK_EN] = is_mchk;
        return m;
    endfunction

endpackage

// File: rtl/crit_fault_track.sv
// Module: crit_fault_track
// Keeps the machine-check sources. A fetch bus error is stored with its
// fetch address and turns into a pending instruction machine check only when
// that address starts execution. A data bus error is stored with the next
// sequential address. Assumes flush_i is high on every accepted redirect.
module crit_fault_track #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ifetch_err_i,
    input  logic [AW-1:0] ifetch_addr_i,
    input  logic          exec_valid_i,
    input  logic [AW-1:0] exec_pc_i,
    input  logic          dbus_err_i,
    input  logic [AW-1:0] next_pc_i,
    input  logic          flush_i,
    input  logic          take_imc_i,
    input  logic          take_dmc_i,
    output logic          imc_pend_o,
    output logic [AW-1:0] imc_addr_o,
    output logic          dmc_pend_o,
    output logic [AW-1:0] dmc_ret_o
);

    logic          fb_valid_q;
    logic [AW-1:0] fb_tag_q;
    logic          imc_pend_q;
    logic [AW-1:0] imc_addr_q;
    logic          dmc_pend_q;
    logic [AW-1:0] dmc_ret_q;
    logic          fb_hit;

    // execution reached the instruction whose fetch failed
    assign fb_hit = fb_valid_q && exec_valid_i && (exec_pc_i == fb_tag_q);

    // record of fetch errors, dropped on redirect or when promoted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_valid_q <= 1'b0;
            fb_tag_q   <= '0;
        end else if (flush_i) begin
            fb_valid_q <= 1'b0;
        end else if (ifetch_err_i) begin
            fb_valid_q <= 1'b1;
            fb_tag_q   <= ifetch_addr_i;
        end else if (fb_hit) begin
            fb_valid_q <= 1'b0;
        end
    end

    // pending instruction-side machine check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imc_pend_q <= 1'b0;
            imc_addr_q <= '0;
        end else if (take_imc_i) begin
            imc_pend_q <= 1'b0;
        end else if (fb_hit && !flush_i && !imc_pend_q) begin
            imc_pend_q <= 1'b1;
            imc_addr_q <= exec_pc_i;
        end
    end

    // pending data-side machine check, first error kept until taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dmc_pend_q <= 1'b0;
            dmc_ret_q  <= '0;
        end else if (dbus_err_i && (!dmc_pend_q || take_dmc_i)) begin
            dmc_pend_q <= 1'b1;
            dmc_ret_q  <= next_pc_i;
        end else if (take_dmc_i) begin
            dmc_pend_q <= 1'b0;
        end
    end

    assign imc_pend_o = imc_pend_q;
    assign imc_addr_o = imc_addr_q;
    assign dmc_pend_o = dmc_pend_q;
    assign dmc_ret_o  = dmc_ret_q;

endmodule

// File: rtl/crit_arbiter.sv
// Module: crit_arbiter
// Picks at most one action per cycle: instruction machine check, data
// machine check, critical input, return. Assumes busy_i is high while the
// previous redirect is still being written back.
module crit_arbiter
    import crit_seq_pkg::*;
(
    input  logic busy_i,
    input  logic imc_pend_i,
    input  logic dmc_pend_i,
    input  logic crit_req_i,
    input  logic rfc_cmd_i,
    input  logic mchk_en_i,
    input  logic crit_en_i,
    output act_e act_o
);

    // fixed-priority selection with enable gating
    always_comb begin
        act_o = ACT_NONE;
        if (!busy_i) begin
            if (imc_pend_i && mchk_en_i) begin
                act_o = ACT_IMC;
            end else if (dmc_pend_i && mchk_en_i) begin
                act_o = ACT_DMC;
            end else if (crit_req_i && crit_en_i) begin
                act_o = ACT_CRIT;
            end else if (rfc_cmd_i) begin
                act_o = ACT_RET;
            end
        end
    end

endmodule

// File: rtl/crit_state_xform.sv
// Module: crit_state_xform
// Builds the target PC, the rewritten status word and the address to save
// for the chosen action. Purely combinational. Assumes AW > PFX_W.
module crit_state_xform
    import crit_seq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int PFX_W = 16,
    parameter int OFF_W = AW - PFX_W,
    parameter logic [OFF_W-1:0] CRIT_OFF = OFF_W'(16'h0100),
    parameter logic [OFF_W-1:0] MCHK_OFF = OFF_W'(16'h0200)
) (
    input  act_e             act_i,
    input  logic [PFX_W-1:0] prefix_i,
    input  logic [ST_W-1:0]  status_i,
    input  logic [AW-1:0]    next_pc_i,
    input  logic [AW-1:0]    imc_addr_i,
    input  logic [AW-1:0]    dmc_ret_i,
    input  logic [AW-1:0]    csave_pc_i,
    input  logic [ST_W-1:0]  csave_st_i,
    output logic [AW-1:0]    target_o,
    output logic [ST_W-1:0]  status_o,
    output logic [AW-1:0]    save_pc_o,
    output logic             save_en_o
);

    localparam logic [ST_W-1:0] CRIT_CLR = entry_clear_mask(1'b0);
    localparam logic [ST_W-1:0] MCHK_CLR = entry_clear_mask(1'b1);

    // per-action target, status and save address
    always_comb begin
        target_o  = csave_pc_i;
        status_o  = csave_st_i;
        save_pc_o = next_pc_i;
        save_en_o = 1'b0;
        unique case (act_i)
            ACT_CRIT: begin
                target_o  = {prefix_i, CRIT_OFF};
                status_o  = status_i & ~CRIT_CLR;
                save_pc_o = next_pc_i;
                save_en_o = 1'b1;
            end
            ACT_IMC: begin
                target_o  = {prefix_i, MCHK_OFF};
                status_o  = status_i & ~MCHK_CLR;
                save_pc_o = imc_addr_i;
                save_en_o = 1'b1;
            end
            ACT_DMC: begin
                target_o  = {prefix_i, MCHK_OFF};
                status_o  = status_i & ~MCHK_CLR;
                save_pc_o = dmc_ret_i;
                save_en_o = 1'b1;
            end
            default: begin
                target_o  = csave_pc_i;
                status_o  = csave_st_i;
                save_en_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/crit_exc_sequencer.sv
// Module: crit_exc_sequencer (top)
// Takes critical inputs and machine checks, stores the critical save pair,
// rewrites the status word and redirects the core; also serves the
// return-from-critical command. Assumes the status register sits outside
// and is written from status_o while status_we_o is high.
module crit_exc_sequencer
    import crit_seq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int PFX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             crit_req_i,
    input  logic             ifetch_err_i,
    input  logic [AW-1:0]    ifetch_addr_i,
    input  logic             exec_valid_i,
    input  logic [AW-1:0]    exec_pc_i,
    input  logic             dbus_err_i,
    input  logic [AW-1:0]    next_pc_i,
    input  logic             rfc_cmd_i,
    input  logic [31:0]      status_i,
    input  logic [PFX_W-1:0] vec_prefix_i,
    output logic             redirect_o,
    output logic [AW-1:0]    target_pc_o,
    output logic             status_we_o,
    output logic [31:0]      status_o,
    output logic [AW-1:0]    csave_pc_o,
    output logic [31:0]      csave_st_o
);

    act_e            act;
    logic            accept;
    logic            imc_pend;
    logic            dmc_pend;
    logic [AW-1:0]   imc_addr;
    logic [AW-1:0]   dmc_ret;
    logic [AW-1:0]   nx_target;
    logic [ST_W-1:0] nx_status;
    logic [AW-1:0]   nx_save_pc;
    logic            nx_save_en;

    logic            redirect_q;
    logic [AW-1:0]   target_q;
    logic [ST_W-1:0] status_q;
    logic [AW-1:0]   csave_pc_q;
    logic [ST_W-1:0] csave_st_q;

    assign accept = (act != ACT_NONE);

    crit_fault_track #(.AW(AW)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .ifetch_err_i (ifetch_err_i),
        .ifetch_addr_i(ifetch_addr_i),
        .exec_valid_i (exec_valid_i),
        .exec_pc_i    (exec_pc_i),
        .dbus_err_i   (dbus_err_i),
        .next_pc_i    (next_pc_i),
        .flush_i      (accept),
        .take_imc_i   (act == ACT_IMC),
        .take_dmc_i   (act == ACT_DMC),
        .imc_pend_o   (imc_pend),
        .imc_addr_o   (imc_addr),
        .dmc_pend_o   (dmc_pend),
        .dmc_ret_o    (dmc_ret)
    );

    crit_arbiter u_arb (
        .busy_i    (redirect_q),
        .imc_pend_i(imc_pend),
        .dmc_pend_i(dmc_pend),
        .crit_req_i(crit_req_i),
        .rfc_cmd_i (rfc_cmd_i),
        .mchk_en_i (status_i[SB_MCHK_EN]),
        .crit_en_i (status_i[SB_CRIT_EN]),
        .act_o     (act)
    );

    crit_state_xform #(.AW(AW), .PFX_W(PFX_W)) u_xform (
        .act_i     (act),
        .prefix_i  (vec_prefix_i),
        .status_i  (status_i),
        .next_pc_i (next_pc_i),
        .imc_addr_i(imc_addr),
        .dmc_ret_i (dmc_ret),
        .csave_pc_i(csave_pc_q),
        .csave_st_i(csave_st_q),
        .target_o  (nx_target),
        .status_o  (nx_status),
        .save_pc_o (nx_save_pc),
        .save_en_o (nx_save_en)
    );

    // redirect pulse, target and status write-back registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_q <= 1'b0;
            target_q   <= '0;
            status_q   <= '0;
        end else begin
            redirect_q <= accept;
            if (accept) begin
                target_q <= nx_target;
                status_q <= nx_status;
            end
        end
    end

    // critical save pair, loaded only on entries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csave_pc_q <= '0;
            csave_st_q <= '0;
        end else if (accept && nx_save_en) begin
            csave_pc_q <= nx_save_pc;
            csave_st_q <= status_i;
        end
    end

    assign redirect_o  = redirect_q;
    assign status_we_o = redirect_q;
    assign target_pc_o = target_q;
    assign status_o    = status_q;
    assign csave_pc_o  = csave_pc_q;
    assign csave_st_o  = csave_st_q;

endmodule

// File: rtl/crit_exc_sequencer_chk.sv
// Module: crit_exc_sequencer_chk
// Property checker bound to crit_exc_sequencer; observes ports and the
// arbiter decision.
module crit_exc_sequencer_chk
    import crit_seq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int PFX_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input act_e             act,
    input logic [31:0]      status_i,
    input logic [AW-1:0]    next_pc_i,
    input logic [PFX_W-1:0] vec_prefix_i,
    input logic             redirect_o,
    input logic [AW-1:0]    target_pc_o,
    input logic [31:0]      status_o,
    input logic [AW-1:0]    csave_pc_o,
    input logic [31:0]      csave_st_o
);

    localparam int OFF_W = AW - PFX_W;

    // R11
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o);

    // R1
    crit_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_CRIT) |=> (csave_pc_o == $past(next_pc_i)) && (csave_st_o == $past(status_i)));

    // R2
    crit_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_CRIT) |=> !status_o[SB_CRIT_EN] && !status_o[SB_EXT_EN] && !status_o[SB_USER]
                              && (status_o[SB_MCHK_EN] == $past(status_i[SB_MCHK_EN])));

    // R3
    crit_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_CRIT) |=> (target_pc_o == {$past(vec_prefix_i), OFF_W'(16'h0100)}));

    // R4
    mchk_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_IMC || act == ACT_DMC) |=> (target_pc_o == {$past(vec_prefix_i), OFF_W'(16'h0200)})
                                            && !status_o[SB_MCHK_EN] && !status_o[SB_CRIT_EN]);

    // R7
    crit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_CRIT) |-> status_i[SB_CRIT_EN]);

    // R7
    mchk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_IMC || act == ACT_DMC) |-> status_i[SB_MCHK_EN]);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (act == ACT_NONE));

    // R9
    return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_RET) |=> (target_pc_o == $past(csave_pc_o)) && (status_o == $past(csave_st_o))
                          && $stable(csave_pc_o) && $stable(csave_st_o));

    // R9
    save_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(csave_st_o) |-> redirect_o);

endmodule

bind crit_exc_sequencer crit_exc_sequencer_chk #(.AW(AW), .PFX_W(PFX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .act         (act),
    .status_i    (status_i),
    .next_pc_i   (next_pc_i),
    .vec_prefix_i(vec_prefix_i),
    .redirect_o  (redirect_o),
    .target_pc_o (target_pc_o),
    .status_o    (status_o),
    .csave_pc_o  (csave_pc_o),
    .csave_st_o  (csave_st_o)
);

// File: tb/crit_exc_sequencer_test.sv
// Bench for crit_exc_sequencer: sweeps entry/return patterns and corner cases.
module crit_exc_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        crit_req = 1'b0;
    logic        ifetch_err = 1'b0;
    logic [31:0] ifetch_addr = '0;
    logic        exec_valid = 1'b0;
    logic [31:0] exec_pc = '0;
    logic        dbus_err = 1'b0;
    logic [31:0] next_pc = '0;
    logic        rfc_cmd = 1'b0;
    logic [31:0] st_reg = '0;
    logic [15:0] prefix = '0;
    logic        redirect;
    logic [31:0] target_pc;
    logic        status_we;
    logic [31:0] status_out;
    logic [31:0] csave_pc;
    logic [31:0] csave_st;

    int nchecks = 0;
    int nerr = 0;
    bit done = 0;

    localparam logic [31:0] CRIT_CLR = 32'h0000_3FFB;
    localparam logic [31:0] MCHK_CLR = 32'h0000_3FFF;

    always #5 clk = ~clk;

    crit_exc_sequencer uut (
        .clk(clk), .rst_n(rst_n), .crit_req_i(crit_req), .ifetch_err_i(ifetch_err),
        .ifetch_addr_i(ifetch_addr), .exec_valid_i(exec_valid), .exec_pc_i(exec_pc),
        .dbus_err_i(dbus_err), .next_pc_i(next_pc), .rfc_cmd_i(rfc_cmd),
        .status_i(st_reg), .vec_prefix_i(prefix), .redirect_o(redirect),
        .target_pc_o(target_pc), .status_we_o(status_we), .status_o(status_out),
        .csave_pc_o(csave_pc), .csave_st_o(csave_st)
    );

    // external status register as a core would hold it
    always @(posedge clk) begin
        if (status_we) st_reg <= status_out;
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        nchecks++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // return from the handler and confirm the restore
    task automatic do_return(input logic [31:0] exp_pc, input logic [31:0] exp_st);
        rfc_cmd = 1'b1;
        next_pc = 32'hDEAD_0000;
        tick();
        rfc_cmd = 1'b0;
        chk("R9 ret redirect", {31'd0, redirect}, 32'd1);
        chk("R9 ret pc", target_pc, exp_pc);
        chk("R9 ret status", status_out, exp_st);
        tick();
        chk("R11 ret pulse", {31'd0, redirect}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchecks++;
            nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        logic [31:0] np;
        logic [15:0] pf;
        tick();
        tick();
        // R12 reset state
        chk("R12 redirect", {31'd0, redirect}, 32'd0);
        chk("R12 we", {31'd0, status_we}, 32'd0);
        chk("R12 target", target_pc, 32'd0);
        chk("R12 status", status_out, 32'd0);
        chk("R12 csave_pc", csave_pc, 32'd0);
        chk("R12 csave_st", csave_st, 32'd0);
        rst_n = 1'b1;
        tick();
        chk("R12 idle after reset", {31'd0, redirect}, 32'd0);

        // R1 R2 R3 R9 R11: critical input sweep
        for (int i = 0; i < 48; i++) begin
            s  = (i * 32'h9E37_79B1) ^ (32'h0000_0001 << (i % 14)) | 32'h0000_0002;
            pf = 16'(i * 16'h1357 + 16'h0040);
            np = (i * 32'h0101_0404) & ~32'h3;
            st_reg = s;
            prefix = pf;
            next_pc = np;
            crit_req = 1'b1;
            tick();
            crit_req = 1'b0;
            chk("R11 crit redirect", {31'd0, redirect}, 32'd1);
            chk("R11 crit we", {31'd0, status_we}, 32'd1);
            chk("R3 crit vector", target_pc, {pf, 16'h0100});
            chk("R2 crit status", status_out, s & ~CRIT_CLR);
            chk("R1 crit save pc", csave_pc, np);
            chk("R1 crit save st", csave_st, s);
            tick();
            chk("R11 crit pulse", {31'd0, redirect}, 32'd0);
            do_return(np, s);
        end

        // R7: critical input blocked while bit 1 is 0, served once enabled
        st_reg = 32'h0000_0004;
        next_pc = 32'h0000_1230;
        prefix = 16'hA5A5;
        crit_req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R7 crit blocked", {31'd0, redirect}, 32'd0);
        end
        st_reg = 32'h0000_0006;
        tick();
        crit_req = 1'b0;
        chk("R7 crit served", target_pc, 32'hA5A5_0100);
        chk("R7 crit served save", csave_pc, 32'h0000_1230);
        tick();
        do_return(32'h0000_1230, 32'h0000_0006);

        // R4 R5: data machine check sweep
        for (int i = 0; i < 16; i++) begin
            s  = (i * 32'h7F4A_7C15) | 32'h0000_0004;
            pf = 16'(16'h8000 + i * 16'h0111);
            np = 32'h0040_0000 + i * 32'h0000_0010;
            st_reg = s;
            prefix = pf;
            next_pc = np;
            dbus_err = 1'b1;
            tick();
            dbus_err = 1'b0;
            next_pc = 32'hFFFF_0000;
            chk("R5 dmc latency", {31'd0, redirect}, 32'd0);
            tick();
            chk("R4 dmc redirect", {31'd0, redirect}, 32'd1);
            chk("R4 dmc vector", target_pc, {pf, 16'h0200});
            chk("R4 dmc status", status_out, s & ~MCHK_CLR);
            chk("R5 dmc save pc", csave_pc, np);
            chk("R5 dmc save st", csave_st, s);
            tick();
            do_return(np, s);
        end

        // R6: fetch error waits for execution of that address
        st_reg = 32'h1234_0006;
        prefix = 16'h00F0;
        ifetch_addr = 32'h0000_8880;
        ifetch_err = 1'b1;
        tick();
        ifetch_err = 1'b0;
        tick();
        chk("R6 no trap at fetch", {31'd0, redirect}, 32'd0);
        tick();
        chk("R6 no trap at fetch", {31'd0, redirect}, 32'd0);
        exec_valid = 1'b1;
        exec_pc = 32'h0000_8884;
        tick();
        chk("R6 other address", {31'd0, redirect}, 32'd0);
        exec_pc = 32'h0000_8880;
        tick();
        exec_valid = 1'b0;
        chk("R6 imc latency", {31'd0, redirect}, 32'd0);
        tick();
        chk("R6 imc redirect", {31'd0, redirect}, 32'd1);
        chk("R6 imc vector", target_pc, 32'h00F0_0200);
        chk("R6 imc save pc", csave_pc, 32'h0000_8880);
        chk("R4 imc status", status_out, 32'h1234_0006 & ~MCHK_CLR);
        tick();
        do_return(32'h0000_8880, 32'h1234_0006);

        // R10: recorded fetch error dropped by an intervening redirect
        ifetch_addr = 32'h0000_9990;
        ifetch_err = 1'b1;
        tick();
        ifetch_err = 1'b0;
        next_pc = 32'h0000_9990;
        crit_req = 1'b1;
        tick();
        crit_req = 1'b0;
        chk("R10 crit taken", target_pc, 32'h00F0_0100);
        tick();
        do_return(32'h0000_9990, 32'h1234_0006);
        exec_valid = 1'b1;
        exec_pc = 32'h0000_9990;
        tick();
        exec_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R10 no imc after flush", {31'd0, redirect}, 32'd0);
        end

        // R7: data machine check held while bit 2 is 0
        st_reg = 32'h0000_0000;
        next_pc = 32'h0000_5550;
        dbus_err = 1'b1;
        tick();
        dbus_err = 1'b0;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R7 mchk blocked", {31'd0, redirect}, 32'd0);
        end
        st_reg = 32'h0000_0004;
        tick();
        chk("R7 mchk served", target_pc, 32'h00F0_0200);
        chk("R7 mchk save", csave_pc, 32'h0000_5550);
        tick();
        do_return(32'h0000_5550, 32'h0000_0004);

        // R8: machine check wins over critical input; critical served after return
        st_reg = 32'h0000_0000;
        crit_req = 1'b1;
        next_pc = 32'h0000_6660;
        dbus_err = 1'b1;
        tick();
        dbus_err = 1'b0;
        tick();
        chk("R8 both blocked", {31'd0, redirect}, 32'd0);
        st_reg = 32'h0000_0006;
        next_pc = 32'h0000_7770;
        tick();
        chk("R8 mchk first", target_pc, 32'h00F0_0200);
        chk("R8 mchk save", csave_pc, 32'h0000_6660);
        tick();
        chk("R8 crit masked in handler", {31'd0, redirect}, 32'd0);
        rfc_cmd = 1'b1;
        tick();
        rfc_cmd = 1'b0;
        chk("R8 return", target_pc, 32'h0000_6660);
        tick();
        chk("R8 busy cycle", {31'd0, redirect}, 32'd0);
        tick();
        crit_req = 1'b0;
        chk("R8 crit after return", target_pc, 32'h00F0_0100);
        chk("R8 crit save", csave_pc, 32'h0000_7770);
        tick();
        do_return(32'h0000_7770, 32'h0000_0006);

        // R8: entry beats a simultaneous return
        next_pc = 32'h0000_4440;
        crit_req = 1'b1;
        rfc_cmd = 1'b1;
        tick();
        crit_req = 1'b0;
        rfc_cmd = 1'b0;
        chk("R8 entry over return", target_pc, 32'h00F0_0100);
        chk("R8 entry over return save", csave_pc, 32'h0000_4440);
        tick();
        do_return(32'h0000_4440, 32'h0000_0006);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end

endmodule